// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block collects 8-bit frames from a single serial data line and hands each finished byte to a host through a one-entry receive buffer. The serial clock either comes from the block itself (a divided system-clock output that idles high) or is supplied from outside. In the second case, the outside clock and the data line are brought into the system clock domain before use.

The host starts reception with a level enable, which acts on its 0-to-1 transition. It can stop reception gracefully by dropping the enable, or kill it at once with an abort pulse. The host drains the buffer through a valid/ready pair. `rx_valid` stays high, with `rx_data` stable, until the host accepts the byte: a byte moves on every cycle in which both `rx_valid` and `rx_ready` are high. When the block drives its own clock, an unread buffer is the back-pressure. The serial clock parks high, and no further bit is requested until the host accepts the byte. With an outside clock there is no back-pressure, because the line keeps running.

Top module: `srx_core`

## Requirements
- R1: Each frame has 8 bits. The first bit sampled lands in `rx_data[0]` and the eighth lands in `rx_data[7]`.
- R2: On the clock edge that follows the eighth sample, the byte is loaded into `rx_data` and `rx_valid` rises. `rx_irq` is high for exactly one cycle for each completed byte, and it is never high while `rx_valid` is low.
- R3: Reception begins only on a 0-to-1 transition of `rx_en` while `rx_busy` is low. Serial clock edges seen before that transition load nothing.
- R4: In internal mode (`clk_src_ext` = 0), `sclk_o` is high whenever the block is not shifting. Each low and each high phase lasts `div`+1 system clock cycles, and the input is sampled as `sclk_o` rises.
- R5: In internal mode, `sclk_o` stays high and produces no falling edge while `rx_valid` is high. Shifting resumes only after the host has accepted the byte.
- R6: In external mode (`clk_src_ext` = 1), `sclk_i` and `sdi` pass through two synchronizer flops, and every synchronized rising edge of `sclk_i` samples `sdi`. No waiting is inserted. A byte that completes while the buffer is still full overwrites it and raises another `rx_irq`.
- R7: When `rx_en` falls partway through a byte, the remaining bits are still shifted, the byte is delivered normally, and reception then ends.
- R8: `rx_busy` is 1 from the start of reception until it ends. When `rx_en` is low and no bit of a frame has been taken, `rx_busy` is 0 on the next cycle.
- R9: A cycle with `rx_abort` high clears `rx_busy` on the next cycle and throws away any partial frame. No `rx_irq` and no buffer load follow from it. Reception stays off until `rx_en` makes a new 0-to-1 transition.
- R10: A change of `clk_src_ext` clears the buffer. On the next cycle `rx_valid` is 0 and `rx_data` is 0.
- R11: A cycle with `rx_valid` and `rx_ready` both high removes the byte. On the next cycle `rx_valid` is 0, unless a new byte completed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_src_ext | input | 1 | Clock source select: 0 internal, 1 external |
| div | input | DIV_W | Half-period of the internal serial clock, minus one, in system cycles |
| rx_en | input | 1 | Receive enable; its rising transition starts reception, its fall requests a graceful stop |
| rx_abort | input | 1 | Immediate abort pulse |
| sclk_i | input | 1 | External serial clock |
| sdi | input | 1 | Serial data input |
| sclk_o | output | 1 | Internal serial clock output, idles high |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Host accepts the buffered byte |
| rx_irq | output | 1 | One-cycle buffer-full pulse |
| rx_busy | output | 1 | Reception active |

## Verification
The bench holds the host not ready across two internal-clock bytes. A design that ignores back-pressure would show extra falling edges on `sclk_o` and lose the first byte. The enable is dropped after the fourth bit of a frame: a design that stops at once, instead of finishing the frame, never delivers that byte. An abort is issued mid-frame and followed by stray clock edges, then a fresh byte is sent. A design that keeps the partial bits would deliver a corrupted byte or an extra interrupt. The bench also covers overwriting in external mode, clock edges that arrive before the start, and clearing of the buffer on a mode switch, where a wrong design would leave a stale byte marked valid.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              q_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      q_prev <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], d};
      q_prev <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~q_prev;
endmodule

// File: rtl/srx_sclk_gen.sv
module srx_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             sample
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick   = run && (cnt == div);
  // a sample coincides with the rising transition of the output clock
  assign sample = tick && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [DATA_W-1:0] word_next,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              done
);
  logic [DATA_W-1:0] shreg;

  assign word_next = {din, shreg[DATA_W-1:1]};
  assign done      = shift_en && (bit_idx == IDX_W'(DATA_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (clr) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (shift_en) begin
      shreg   <= word_next;
      bit_idx <= done ? '0 : bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/srx_core.sv
module srx_core
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_src_ext,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_en,
  input  logic              rx_abort,
  input  logic              sclk_i,
  input  logic              sdi,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_irq,
  output logic              rx_busy
);
  clk_src_e          src, src_q;
  logic              en_q, start, mode_chg;
  logic              sclk_s, ext_rise, sdi_s, sdi_rise;
  logic              int_run, int_sample, sample;
  logic [DATA_W-1:0] word_next;
  logic [IDX_W-1:0]  bit_idx;
  logic              done;
  logic              mid_frame;

  assign src       = clk_src_e'(clk_src_ext);
  assign start     = rx_en && !en_q;
  assign mode_chg  = (src != src_q);
  assign mid_frame = (bit_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_INT;
      en_q  <= 1'b0;
    end else begin
      src_q <= src;
      en_q  <= rx_en;
    end
  end

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s), .rise(ext_rise)
  );

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s), .rise(sdi_rise)
  );

  // internal clock parks whenever a byte waits for the host
  assign int_run = rx_busy && (src == SRC_INT) && !rx_valid && !rx_abort
                   && (rx_en || mid_frame);

  srx_sclk_gen #(.DIV_W(DIV_W)) u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .run(int_run), .div(div),
    .sclk(sclk_o), .sample(int_sample)
  );

  always_comb begin
    sample = 1'b0;
    if (rx_busy && !rx_abort) begin
      if (src == SRC_EXT) sample = ext_rise;
      else                sample = int_sample;
    end
  end

  srx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .clr(!rx_busy || rx_abort),
    .shift_en(sample), .din(sdi_s),
    .word_next(word_next), .bit_idx(bit_idx), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
    end else if (rx_abort) begin
      rx_busy <= 1'b0;
    end else if (!rx_busy && start) begin
      rx_busy <= 1'b1;
    end else if (rx_busy && !rx_en && !mid_frame && !sample) begin
      rx_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= done && !mode_chg;
      if (mode_chg) begin
        rx_data  <= '0;
        rx_valid <= 1'b0;
      end else if (done) begin
        rx_data  <= word_next;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = sclk_s ^ sdi_rise;
endmodule

// File: rtl/srx_core_chk.sv
module srx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_src_ext,
  input logic              rx_abort,
  input logic              rx_busy,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_irq,
  input logic [DATA_W-1:0] rx_data,
  input logic              sclk_o
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_busy |-> sclk_o);

  assert_sclk_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_src_ext && rx_valid) |-> sclk_o);

  assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_irq_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> (!rx_busy && !rx_irq));

  assert_mode_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_ext != $past(clk_src_ext)) |=> (!rx_valid && rx_data == '0));

  assert_read_drains_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (!rx_valid || rx_irq));
endmodule

bind srx_core srx_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_src_ext(clk_src_ext), .rx_abort(rx_abort),
  .rx_busy(rx_busy), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_irq(rx_irq), .rx_data(rx_data), .sclk_o(sclk_o)
);

// File: tb/srx_core_tb_top.sv
`timescale 1ns/1ps
module srx_core_tb_top;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int DIV    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_src_ext = 1'b0;
  logic [DIV_W-1:0] div = DIV_W'(DIV);
  logic rx_en = 1'b0, rx_abort = 1'b0, sclk_i = 1'b0, sdi = 1'b0, rx_ready = 1'b0;
  logic sclk_o, rx_valid, rx_irq, rx_busy;
  logic [DATA_W-1:0] rx_data;

  int checks = 0, errors = 0;
  int irq_cnt = 0, fall_cnt = 0, low_len = 0, last_low = 0;
  logic [7:0] last_read = 8'h00;
  logic [7:0] exp_q[$];
  logic prev_sclk = 1'b1;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  srx_core #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_src_ext(clk_src_ext), .div(div),
    .rx_en(rx_en), .rx_abort(rx_abort), .sclk_i(sclk_i), .sdi(sdi),
    .sclk_o(sclk_o), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .rx_busy(rx_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each handshake, plus clock statistics
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq) irq_cnt++;
      if (prev_sclk && !sclk_o) fall_cnt++;
      if (!sclk_o) low_len++;
      else if (low_len != 0) begin last_low = low_len; low_len = 0; end
      prev_sclk = sclk_o;
      if (rx_valid && rx_ready) begin
        last_read = rx_data;
        if (exp_q.size() == 0) chk(0, "R1 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R1 scoreboard", rx_data, e);
        end
      end
    end
  end

  task automatic at_edge();
    @(posedge clk); #1;
  endtask

  task automatic restart();
    at_edge(); rx_en = 1'b0;
    at_edge(); rx_en = 1'b1;
  endtask

  task automatic drive_int(input logic [7:0] b, input int stop_at);
    exp_q.push_back(b);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_o); #1;
      sdi = b[i];
      if (i == stop_at) rx_en = 1'b0;
    end
    @(posedge sclk_o);
  endtask

  task automatic drive_ext(input logic [7:0] b, input int nbits);
    if (nbits == 8) exp_q.push_back(b);
    for (int i = 0; i < nbits; i++) begin
      at_edge(); sdi = b[i];
      repeat (4) at_edge();
      sclk_i = 1'b1;
      repeat (4) at_edge();
      sclk_i = 1'b0;
    end
    repeat (4) at_edge();
  endtask

  task automatic drain();
    while (exp_q.size() != 0) at_edge();
    repeat (3) at_edge();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0, i0;
    repeat (4) at_edge();
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 0, "R2 reset valid", rx_valid, 0);
    chk(rx_busy == 0, "R8 reset busy", rx_busy, 0);
    chk(sclk_o == 1, "R4 reset sclk idle", sclk_o, 1);
    chk(rx_irq == 0, "R2 reset irq", rx_irq, 0);

    // internal clock, host always ready
    rx_ready = 1'b1;
    restart();
    drive_int(8'hA5, -1);
    drive_int(8'h3C, -1);
    drain();
    chk(irq_cnt == 2, "R2 irq count", irq_cnt, 2);
    chk(last_low == DIV + 1, "R4 half period", last_low, DIV + 1);
    chk(last_read == 8'h3C, "R1 lsb first", last_read, 8'h3C);
    at_edge(); rx_en = 1'b0;
    repeat (3) at_edge();
    @(negedge clk);
    chk(rx_busy == 0, "R8 idle stop", rx_busy, 0);
    chk(sclk_o == 1, "R4 idle high", sclk_o, 1);

    // back-pressure in internal mode
    rx_ready = 1'b0;
    i0 = irq_cnt;
    restart();
    fork
      begin drive_int(8'h5A, -1); drive_int(8'hC3, -1); done_flag = 1; end
    join_none
    while (!rx_valid) at_edge();
    f0 = fall_cnt;
    repeat (40) at_edge();
    @(negedge clk);
    chk(fall_cnt == f0, "R5 no falls while full", fall_cnt, f0);
    chk(sclk_o == 1 && rx_busy == 1, "R5 parked high", {sclk_o, rx_busy}, 3);
    chk(irq_cnt == i0 + 1, "R2 one irq", irq_cnt, i0 + 1);
    at_edge(); rx_ready = 1'b1;
    while (!done_flag) at_edge();
    drain();
    chk(last_read == 8'hC3, "R5 resumed byte", last_read, 8'hC3);

    // graceful stop mid-byte
    restart();
    drive_int(8'h96, 3);
    drain();
    @(negedge clk);
    chk(last_read == 8'h96, "R7 finished byte", last_read, 8'h96);
    chk(rx_busy == 0, "R7 ended", rx_busy, 0);

    // external mode: edges before start ignored
    at_edge(); clk_src_ext = 1'b1; rx_ready = 1'b0; rx_en = 1'b0;
    i0 = irq_cnt;
    drive_ext(8'hFF, 8);
    void'(exp_q.pop_back());
    @(negedge clk);
    chk(irq_cnt == i0 && rx_valid == 0, "R3 no start no capture", irq_cnt, i0);
    restart();
    drive_ext(8'h11, 8);
    drive_ext(8'hE7, 8);
    @(negedge clk);
    chk(irq_cnt == i0 + 2, "R6 irq per byte", irq_cnt, i0 + 2);
    chk(rx_valid == 1 && rx_data == 8'hE7, "R6 overwrite", rx_data, 8'hE7);
    void'(exp_q.pop_front());
    at_edge(); rx_ready = 1'b1;
    at_edge(); at_edge();
    @(negedge clk);
    chk(rx_valid == 0, "R11 read clears", rx_valid, 0);
    drain();

    // abort mid-frame
    drive_ext(8'hF0, 4);
    at_edge(); rx_abort = 1'b1;
    at_edge(); rx_abort = 1'b0;
    @(negedge clk);
    chk(rx_busy == 0, "R9 busy cleared", rx_busy, 0);
    i0 = irq_cnt;
    drive_ext(8'h0F, 4);
    @(negedge clk);
    chk(irq_cnt == i0 && rx_valid == 0, "R9 no irq after abort", irq_cnt, i0);
    restart();
    drive_ext(8'h4B, 8);
    drain();
    chk(last_read == 8'h4B, "R9 partial discarded", last_read, 8'h4B);

    // mode change clears the buffer
    at_edge(); rx_ready = 1'b0;
    drive_ext(8'h77, 8);
    void'(exp_q.pop_back());
    @(negedge clk);
    chk(rx_valid == 1, "R10 byte pending", rx_valid, 1);
    at_edge(); rx_en = 1'b0;
    repeat (3) at_edge();
    clk_src_ext = 1'b0;
    at_edge();
    @(negedge clk);
    chk(rx_valid == 0 && rx_data == 8'h00, "R10 cleared", rx_data, 0);
    chk(rx_busy == 0, "R8 stopped", rx_busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule